// File: doc/BRIEF.md
# Two-Bit Cell Write and Refresh Controller

This block drives one row at a time of an array whose cells each hold two bits. One bit is volatile and the other is nonvolatile. A user command asks for a row to receive a volatile write, a nonvolatile write or a refresh. The block reads its own copy of the row's cell states. From the current and target state of each cell it picks a 3-bit control-gate level code and a 3-bit select-line level code for every cell, plus a pulse length. It holds those codes for that many clock cycles and then updates its copy of the row. Cells that are not asked to change, or that already hold the target value, get a retain envelope. The block puts out level codes and timing only; the analogue drivers that turn codes into voltages sit elsewhere.

A volatile 1 leaks away, so a slot timer divides the refresh window evenly across the rows. In each slot the block senses one row for one cycle and then rewrites every volatile 1 in that row. Commands enter on a valid/ready handshake. A command is taken on any clock edge where `cmd_valid` and `cmd_ready` are both high. The requester must hold the command fields stable while `cmd_valid` is high and `cmd_ready` is low. `cmd_ready` is low while an operation runs or while a refresh is due, so a refresh never breaks into a write and always goes ahead of the next queued command.

Level codes: 0 = 0 V, 1 = +2 V, 2 = +3 V, 3 = +7 V, 5 = -2 V, 6 = -3 V, 7 = -7 V. Cell c uses bits [3c+2:3c] of `cg_code` and `sl_code`. Command codes on `cmd_op`: 0 = volatile write, 1 = nonvolatile write, 2 or 3 = refresh of `cmd_row`.

Top module: `twobit_wr_ctrl`

## Requirements
- R1: After reset, busy, done, sense_en and drv_active are low, every level code is 0, cmd_ready is high, and every stored cell state is volatile 0, nonvolatile 0.
- R2: A command is taken on an edge where cmd_valid and cmd_ready are both high. busy is high from the next cycle until the envelope ends. In the cycle after the envelope, done is high for exactly one cycle and busy is low.
- R3: A volatile write of 1 drives control-gate code 2 on all cells of the row. Each changing cell (in cmd_mask and volatile bit 0) gets select code 5; every other cell gets select code 1. The pulse lasts the 30 ns duration if every changing cell has nonvolatile bit 0, else the 40 ns duration.
- R4: A volatile write of 0 drives control-gate code 6 on all cells. Changing cells get select code 1 and the others select code 5. The pulse lasts the 1 ms duration.
- R5: A cell outside cmd_mask, or one that already holds the target value, keeps its stored state. If no cell changes, drv_active stays low and done still pulses.
- R6: A nonvolatile write gives each changing cell (in cmd_mask, nonvolatile bit differing from cmd_val) control-gate code 3 if its volatile bit is 0, or 7 if it is 1, with select code 0; other cells get 0 on both lines. Setting lasts 30 µs, clearing 7.5 µs, and volatile bits are unchanged.
- R7: Each duration in cycles is the nanosecond parameter divided by the clock period, rounded up. When cells need different lengths, the row uses the longest.
- R8: Every refresh begins with exactly one cycle of sense_en high while drv_active is low. sense_en is never high during a drive.
- R9: A refresh rewrite drives control-gate code 2 on all cells, select code 5 on cells holding volatile 1 and select code 1 on the rest. Its length follows R3 over the volatile-1 cells, and a row with no volatile 1 gets no drive.
- R10: Timed refreshes start one per slot of (window cycles / rows) and visit rows 0, 1, 2, … in order, wrapping to 0.
- R11: A refresh that falls due during an operation waits until that operation ends. It then runs before any further command, with cmd_ready low while it is due.
- R12: A command with code 2 or 3 refreshes cmd_row under R8/R9, ignores cmd_mask and cmd_val, and ends with done. Timed refreshes raise no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Command code |
| cmd_row | input | log2(NROW) | Target row |
| cmd_mask | input | NCELL | Cells that may change |
| cmd_val | input | 1 | Target bit value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse for user commands |
| sense_en | output | 1 | Read circuitry enabled (refresh sense cycle) |
| drv_active | output | 1 | Row drivers enabled, envelope in progress |
| drv_row | output | log2(NROW) | Row being sensed or driven, else 0 |
| cg_code | output | 3*NCELL | Control-gate level code per cell |
| sl_code | output | 3*NCELL | Select-line level code per cell |

## Verification
Directed sequences on one row step a cell through every transition: volatile set with the nonvolatile bit clear and set, volatile clear, nonvolatile set and clear under both volatile values, and repeated writes that change nothing. Together they separate the 30/40 ns, 1 ms and set/clear timings, the per-cell ±7 V choice, and the zero-length case. Random commands over random rows and masks then mix retaining and changing cells in one row, which shows whether the longest-duration rule and the retain select polarity hold. Idle stretches and long writes test the order of timed refreshes and the rule that a refresh falling due is deferred but never lost.

// File: rtl/twobit_pkg.sv
package twobit_pkg;

  typedef enum logic [2:0] {
    LV_ZERO = 3'd0,
    LV_POS2 = 3'd1,
    LV_POS3 = 3'd2,
    LV_POS7 = 3'd3,
    LV_NEG2 = 3'd5,
    LV_NEG3 = 3'd6,
    LV_NEG7 = 3'd7
  } level_e;

  typedef enum logic [1:0] {
    OP_VOL     = 2'd0,
    OP_NV      = 2'd1,
    OP_REF     = 2'd2,
    OP_REF_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_CALC  = 2'd2,
    ST_DRIVE = 2'd3
  } fsm_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input int unsigned clk_ps);
    longint unsigned tot;
    tot = (ns * 64'd1000 + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    return tot[31:0];
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/twobit_shadow.sv
module twobit_shadow #(
  parameter int unsigned NROW  = 128,
  parameter int unsigned NCELL = 8,
  localparam int unsigned RW   = $clog2(NROW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    rd_row,
  output logic [NCELL-1:0] rd_v,
  output logic [NCELL-1:0] rd_nv,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_row,
  input  logic [NCELL-1:0] wr_v,
  input  logic [NCELL-1:0] wr_nv
);

  logic [NCELL-1:0] vmem  [NROW];
  logic [NCELL-1:0] nvmem [NROW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(NROW); r++) begin
        vmem[r]  <= '0;
        nvmem[r] <= '0;
      end
    end else if (wr_en) begin
      vmem[wr_row]  <= wr_v;
      nvmem[wr_row] <= wr_nv;
    end
  end

  assign rd_v  = vmem[rd_row];
  assign rd_nv = nvmem[rd_row];

endmodule

// File: rtl/twobit_plan.sv
module twobit_plan import twobit_pkg::*; #(
  parameter int unsigned NCELL = 8,
  parameter int unsigned DUR_W = 18,
  parameter int unsigned T_V1A = 6,
  parameter int unsigned T_V1B = 8,
  parameter int unsigned T_V0  = 200000,
  parameter int unsigned T_NVS = 6000,
  parameter int unsigned T_NVC = 1500
) (
  input  op_e                op,
  input  logic               val,
  input  logic [NCELL-1:0]   mask,
  input  logic [NCELL-1:0]   vcur,
  input  logic [NCELL-1:0]   nvcur,
  output logic [3*NCELL-1:0] cg,
  output logic [3*NCELL-1:0] sl,
  output logic [NCELL-1:0]   vnext,
  output logic [NCELL-1:0]   nvnext,
  output logic [DUR_W-1:0]   dur
);

  logic [DUR_W-1:0] dcell [NCELL];

  for (genvar c = 0; c < int'(NCELL); c++) begin : g_cell
    logic             chg;
    logic             vn;
    logic             nvn;
    level_e           cgc;
    level_e           slc;
    logic [DUR_W-1:0] dc;

    always_comb begin
      chg = 1'b0;
      vn  = vcur[c];
      nvn = nvcur[c];
      cgc = LV_ZERO;
      slc = LV_ZERO;
      dc  = '0;
      case (op)
        OP_VOL: begin
          chg = mask[c] && (vcur[c] != val);
          cgc = val ? LV_POS3 : LV_NEG3;
          if (val) slc = chg ? LV_NEG2 : LV_POS2;
          else     slc = chg ? LV_POS2 : LV_NEG2;
          if (chg) begin
            vn = val;
            if (val) dc = nvcur[c] ? DUR_W'(T_V1B) : DUR_W'(T_V1A);
            else     dc = DUR_W'(T_V0);
          end
        end
        OP_NV: begin
          chg = mask[c] && (nvcur[c] != val);
          if (chg) begin
            cgc = vcur[c] ? LV_NEG7 : LV_POS7;
            nvn = val;
            dc  = val ? DUR_W'(T_NVS) : DUR_W'(T_NVC);
          end
        end
        default: begin
          chg = vcur[c];
          cgc = LV_POS3;
          slc = chg ? LV_NEG2 : LV_POS2;
          if (chg) dc = nvcur[c] ? DUR_W'(T_V1B) : DUR_W'(T_V1A);
        end
      endcase
    end

    assign cg[3*c +: 3] = cgc;
    assign sl[3*c +: 3] = slc;
    assign vnext[c]     = vn;
    assign nvnext[c]    = nvn;
    assign dcell[c]     = dc;
  end

  // Row pulse length is the longest any cell needs.
  always_comb begin
    dur = '0;
    for (int c = 0; c < int'(NCELL); c++) begin
      if (dcell[c] > dur) dur = dcell[c];
    end
  end

endmodule

// File: rtl/twobit_refresh_timer.sv
module twobit_refresh_timer #(
  parameter int unsigned NROW = 128,
  parameter int unsigned SLOT = 93750,
  localparam int unsigned RW  = $clog2(NROW),
  localparam int unsigned SW  = $clog2(SLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic          due,
  output logic [RW-1:0] row
);

  logic [SW-1:0] slot_cnt;
  logic          wrap;

  assign wrap = (slot_cnt == SW'(SLOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      due      <= 1'b0;
      row      <= '0;
    end else begin
      slot_cnt <= wrap ? '0 : slot_cnt + SW'(1);
      if (take) begin
        due <= 1'b0;
        row <= (row == RW'(NROW - 1)) ? '0 : row + RW'(1);
      end
      if (wrap) due <= 1'b1;
    end
  end

endmodule

// File: rtl/twobit_wr_ctrl.sv
module twobit_wr_ctrl import twobit_pkg::*; #(
  parameter int unsigned NCELL          = 8,
  parameter int unsigned NROW           = 128,
  parameter int unsigned CLK_PS         = 5000,
  parameter int unsigned V1_NV0_NS      = 30,
  parameter int unsigned V1_NV1_NS      = 40,
  parameter int unsigned V0_NS          = 1_000_000,
  parameter int unsigned NV_SET_NS      = 30_000,
  parameter int unsigned NV_CLR_NS      = 7_500,
  parameter int unsigned REFRESH_WIN_NS = 60_000_000,
  localparam int unsigned RW            = $clog2(NROW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [RW-1:0]      cmd_row,
  input  logic [NCELL-1:0]   cmd_mask,
  input  logic               cmd_val,
  output logic               busy,
  output logic               done,
  output logic               sense_en,
  output logic               drv_active,
  output logic [RW-1:0]      drv_row,
  output logic [3*NCELL-1:0] cg_code,
  output logic [3*NCELL-1:0] sl_code
);

  localparam int unsigned C_V1A  = ns_to_cycles(V1_NV0_NS, CLK_PS);
  localparam int unsigned C_V1B  = ns_to_cycles(V1_NV1_NS, CLK_PS);
  localparam int unsigned C_V0   = ns_to_cycles(V0_NS, CLK_PS);
  localparam int unsigned C_NVS  = ns_to_cycles(NV_SET_NS, CLK_PS);
  localparam int unsigned C_NVC  = ns_to_cycles(NV_CLR_NS, CLK_PS);
  localparam int unsigned C_SLOT = ns_to_cycles(REFRESH_WIN_NS, CLK_PS) / NROW;
  localparam int unsigned DMAX   = umax(umax(umax(C_V1A, C_V1B), umax(C_V0, C_NVS)), C_NVC);
  localparam int unsigned DUR_W  = $clog2(DMAX + 1);
  localparam int unsigned CW     = 3 * NCELL;

  fsm_e             state;
  op_e              op_q;
  logic [RW-1:0]    row_q;
  logic [NCELL-1:0] mask_q;
  logic             val_q;
  logic             user_q;
  logic             done_q;
  logic [DUR_W-1:0] cnt_q;
  logic [CW-1:0]    cg_q;
  logic [CW-1:0]    sl_q;
  logic [NCELL-1:0] vn_q;
  logic [NCELL-1:0] nvn_q;

  logic             ref_due;
  logic [RW-1:0]    ref_row;
  logic             ref_take;
  logic             accept;
  logic             wr_en;

  logic [NCELL-1:0] cur_v;
  logic [NCELL-1:0] cur_nv;
  logic [NCELL-1:0] pl_v;
  logic [NCELL-1:0] pl_nv;
  logic [CW-1:0]    pl_cg;
  logic [CW-1:0]    pl_sl;
  logic [DUR_W-1:0] pl_dur;

  assign cmd_ready = (state == ST_IDLE) && !ref_due;
  assign accept    = cmd_valid && cmd_ready;
  assign ref_take  = (state == ST_IDLE) && ref_due;
  assign wr_en     = (state == ST_DRIVE) && (cnt_q == DUR_W'(1));

  twobit_refresh_timer #(
    .NROW (NROW),
    .SLOT (C_SLOT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (ref_take),
    .due   (ref_due),
    .row   (ref_row)
  );

  twobit_shadow #(
    .NROW  (NROW),
    .NCELL (NCELL)
  ) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_row (row_q),
    .rd_v   (cur_v),
    .rd_nv  (cur_nv),
    .wr_en  (wr_en),
    .wr_row (row_q),
    .wr_v   (vn_q),
    .wr_nv  (nvn_q)
  );

  twobit_plan #(
    .NCELL (NCELL),
    .DUR_W (DUR_W),
    .T_V1A (C_V1A),
    .T_V1B (C_V1B),
    .T_V0  (C_V0),
    .T_NVS (C_NVS),
    .T_NVC (C_NVC)
  ) u_plan (
    .op     (op_q),
    .val    (val_q),
    .mask   (mask_q),
    .vcur   (cur_v),
    .nvcur  (cur_nv),
    .cg     (pl_cg),
    .sl     (pl_sl),
    .vnext  (pl_v),
    .nvnext (pl_nv),
    .dur    (pl_dur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_VOL;
      row_q  <= '0;
      mask_q <= '0;
      val_q  <= 1'b0;
      user_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cg_q   <= '0;
      sl_q   <= '0;
      vn_q   <= '0;
      nvn_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_due) begin
            op_q   <= OP_REF;
            row_q  <= ref_row;
            mask_q <= '0;
            val_q  <= 1'b0;
            user_q <= 1'b0;
            state  <= ST_SENSE;
          end else if (accept) begin
            op_q   <= op_e'(cmd_op);
            row_q  <= cmd_row;
            mask_q <= cmd_mask;
            val_q  <= cmd_val;
            user_q <= 1'b1;
            state  <= cmd_op[1] ? ST_SENSE : ST_CALC;
          end
        end
        ST_SENSE: state <= ST_CALC;
        ST_CALC: begin
          cg_q  <= pl_cg;
          sl_q  <= pl_sl;
          vn_q  <= pl_v;
          nvn_q <= pl_nv;
          cnt_q <= pl_dur;
          if (pl_dur == '0) begin
            state  <= ST_IDLE;
            done_q <= user_q;
          end else begin
            state <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (cnt_q == DUR_W'(1)) begin
            state  <= ST_IDLE;
            done_q <= user_q;
          end else begin
            cnt_q <= cnt_q - DUR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign sense_en   = (state == ST_SENSE);
  assign drv_active = (state == ST_DRIVE);
  assign drv_row    = (state == ST_SENSE || state == ST_DRIVE) ? row_q : '0;
  assign cg_code    = (state == ST_DRIVE) ? cg_q : '0;
  assign sl_code    = (state == ST_DRIVE) ? sl_q : '0;

endmodule

// File: rtl/twobit_wr_ctrl_chk.sv
module twobit_wr_ctrl_chk #(
  parameter int unsigned NCELL = 8,
  parameter int unsigned RW    = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               busy,
  input logic               done,
  input logic               sense_en,
  input logic               drv_active,
  input logic [RW-1:0]      drv_row,
  input logic [3*NCELL-1:0] cg_code,
  input logic [3*NCELL-1:0] sl_code,
  input logic               ref_due
);

  p_sense_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sense_en && drv_active));

  p_sense_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |=> (!sense_en && !drv_active && busy));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_due_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_due && !busy) |-> !cmd_ready);

  p_quiet_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_active |-> (cg_code == '0 && sl_code == '0));

  p_row_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_active && $past(drv_active)) |-> ($stable(drv_row) && $stable(cg_code)));

endmodule

bind twobit_wr_ctrl twobit_wr_ctrl_chk #(
  .NCELL (NCELL),
  .RW    (RW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .done       (done),
  .sense_en   (sense_en),
  .drv_active (drv_active),
  .drv_row    (drv_row),
  .cg_code    (cg_code),
  .sl_code    (sl_code),
  .ref_due    (ref_due)
);

// File: tb/twobit_wr_ctrl_bench.sv
`timescale 1ns/1ps
module twobit_wr_ctrl_bench;

  localparam int NCELL  = 4;
  localparam int NROW   = 8;
  localparam int RW     = 3;
  localparam int CLK_PS = 5000;
  localparam int WIN_NS = 16000;

  function automatic int cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  localparam int D_V1A = (28 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int D_V1B = (40 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int D_V0  = (100 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int D_NVS = (150 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int D_NVC = (50 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SLOT  = ((WIN_NS * 1000) / CLK_PS) / NROW;

  localparam logic [2:0] K_0 = 3'd0, K_P2 = 3'd1, K_P3 = 3'd2, K_P7 = 3'd3;
  localparam logic [2:0] K_N2 = 3'd5, K_N3 = 3'd6, K_N7 = 3'd7;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [1:0]         cmd_op = '0;
  logic [RW-1:0]      cmd_row = '0;
  logic [NCELL-1:0]   cmd_mask = '0;
  logic               cmd_val = 1'b0;
  logic               busy, done, sense_en, drv_active;
  logic [RW-1:0]      drv_row;
  logic [3*NCELL-1:0] cg_code, sl_code;

  always #2.5 clk = ~clk;

  twobit_wr_ctrl #(
    .NCELL(NCELL), .NROW(NROW), .CLK_PS(CLK_PS),
    .V1_NV0_NS(28), .V1_NV1_NS(40), .V0_NS(100),
    .NV_SET_NS(150), .NV_CLR_NS(50), .REFRESH_WIN_NS(WIN_NS)
  ) u_twobit_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_mask(cmd_mask), .cmd_val(cmd_val),
    .busy(busy), .done(done), .sense_en(sense_en), .drv_active(drv_active),
    .drv_row(drv_row), .cg_code(cg_code), .sl_code(sl_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int n_auto = 0;
  int exp_ptr = 0;
  bit inflight = 1'b0;
  bit cur_ref = 1'b0;
  bit r_act = 1'b0;
  int r_row = 0;
  int r_cnt = 0;
  logic mv  [NROW][NCELL];
  logic mnv [NROW][NCELL];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Expected envelope from the requirement tables.
  task automatic plan(input int op, input int row, input logic [NCELL-1:0] mask,
                      input logic val, output int dur,
                      output logic [3*NCELL-1:0] cg, output logic [3*NCELL-1:0] sl);
    dur = 0;
    for (int c = 0; c < NCELL; c++) begin
      logic [2:0] g, s;
      int d;
      bit ch;
      g = K_0; s = K_0; d = 0;
      if (op == 0) begin
        ch = mask[c] && (mv[row][c] != val);
        g = val ? K_P3 : K_N3;
        s = val ? (ch ? K_N2 : K_P2) : (ch ? K_P2 : K_N2);
        if (ch) d = val ? (mnv[row][c] ? D_V1B : D_V1A) : D_V0;
      end else if (op == 1) begin
        ch = mask[c] && (mnv[row][c] != val);
        if (ch) begin
          g = mv[row][c] ? K_N7 : K_P7;
          d = val ? D_NVS : D_NVC;
        end
      end else begin
        ch = mv[row][c];
        g = K_P3;
        s = ch ? K_N2 : K_P2;
        if (ch) d = mnv[row][c] ? D_V1B : D_V1A;
      end
      cg[3*c +: 3] = g;
      sl[3*c +: 3] = s;
      if (d > dur) dur = d;
    end
  endtask

  task automatic apply_model(input int op, input int row,
                             input logic [NCELL-1:0] mask, input logic val);
    for (int c = 0; c < NCELL; c++) begin
      if (mask[c]) begin
        if (op == 0) mv[row][c] = val;
        else if (op == 1) mnv[row][c] = val;
      end
    end
  endtask

  task automatic do_cmd(input int op, input int row, input logic [NCELL-1:0] mask,
                        input logic val, input string req);
    int e_dur, cnt;
    logic [3*NCELL-1:0] e_cg, e_sl;
    bit first, saw_sense;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op[1:0];
    cmd_row   = row[RW-1:0];
    cmd_mask  = mask;
    cmd_val   = val;
    while (!cmd_ready) @(negedge clk);
    plan(op, row, mask, val, e_dur, e_cg, e_sl);
    inflight = 1'b1;
    cur_ref  = (op >= 2);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    cnt = 0; first = 1'b1; saw_sense = 1'b0;
    while (!done) begin
      if (sense_en) saw_sense = 1'b1;
      if (drv_active) begin
        if (first) begin
          check(cg_code == e_cg, req, "control-gate codes", cg_code, e_cg);
          check(sl_code == e_sl, req, "select codes", sl_code, e_sl);
          check(drv_row == row[RW-1:0], req, "driven row", drv_row, row);
          first = 1'b0;
        end
        check(sense_en == 1'b0, "R8", "sense during drive", sense_en, 0);
        cnt++;
      end
      @(negedge clk);
    end
    check(busy == 1'b0, "R2", "busy with done", busy, 0);
    check(cnt == e_dur, (e_dur == 0) ? "R5" : "R7", "drive cycles", cnt, e_dur);
    if (op >= 2) check(saw_sense == 1'b1, "R12", "sense before user refresh", saw_sense, 1);
    apply_model(op, row, mask, val);
    inflight = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R2", "done width", done, 0);
  endtask

  // Timed-refresh monitor: order, deferral, rewrite length.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sense_en) begin
        check(!(inflight && !cur_ref), "R11", "refresh inside user op", inflight, 0);
        if (!inflight) begin
          check(drv_row == exp_ptr[RW-1:0], "R10", "refresh row order", drv_row, exp_ptr);
          exp_ptr = (exp_ptr + 1) % NROW;
          n_auto++;
          r_act = 1'b1;
          r_row = int'(drv_row);
          r_cnt = 0;
        end
      end else if (r_act) begin
        if (drv_active) r_cnt++;
        else if (!busy) begin
          int ed;
          logic [3*NCELL-1:0] g, s;
          plan(2, r_row, '0, 1'b0, ed, g, s);
          check(r_cnt == ed, "R9", "refresh rewrite cycles", r_cnt, ed);
          check(done == 1'b0, "R12", "no done on timed refresh", done, 0);
          r_act = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "R2", "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCELL; c++) begin
        mv[r][c] = 1'b0;
        mnv[r][c] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    check(sense_en == 0 && drv_active == 0, "R1", "enables after reset", {sense_en, drv_active}, 0);
    check(cg_code == '0 && sl_code == '0, "R1", "codes after reset", cg_code | sl_code, 0);
    check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);

    // Directed walk on row 0 cell 0
    do_cmd(0, 0, 4'b0001, 1'b1, "R3");   // v 0->1, nv 0: short pulse
    do_cmd(0, 0, 4'b0001, 1'b1, "R5");   // no change
    do_cmd(0, 0, 4'b0000, 1'b0, "R5");   // empty mask
    do_cmd(1, 0, 4'b0001, 1'b1, "R6");   // nv set while v=1: -7
    do_cmd(1, 0, 4'b0010, 1'b1, "R6");   // nv set while v=0: +7
    do_cmd(0, 0, 4'b0011, 1'b0, "R4");   // v clear
    do_cmd(0, 0, 4'b0111, 1'b1, "R3");   // mixed nv -> long pulse
    do_cmd(2, 0, 4'b1010, 1'b0, "R12");  // user refresh, mask ignored
    do_cmd(1, 0, 4'b0011, 1'b0, "R6");   // nv clear
    do_cmd(3, 5, 4'b1111, 1'b1, "R12");  // alternate code, row with no v1

    // Random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      if (op > 3) op = 0;
      do_cmd(op, int'($urandom_range(0, NROW - 1)), 4'($urandom_range(0, 15)),
             1'($urandom_range(0, 1)), (op == 0) ? "R3" : (op == 1) ? "R6" : "R9");
    end

    // Idle window: timed refreshes only
    repeat (2 * NROW * SLOT) @(negedge clk);
    check(n_auto >= (cycles / SLOT) - 2, "R11", "timed refreshes not lost", n_auto, cycles / SLOT);
    if (cyc(28) != D_V1A) check(1'b0, "R7", "rounding", cyc(28), D_V1A);
    finish_run();
  end

endmodule